// File: doc/BRIEF.md
# Weighted-Recency Victim Selector

This block keeps the replacement state of a single 16-way cache set and names the way to evict next. Each way holds a valid bit, a position in a recency stack (0 is the least recently used line, 15 the most recent) and a 3-bit quantized miss cost. The cost is written when the line is filled. Once every way is valid, the selector scores each way as its stack position plus a programmable weight times its cost. It then offers the way with the lowest score. Lines that are cheap to fetch again therefore leave before costly ones of similar age. With a weight of zero the choice is plain LRU.

The surrounding cache controller reports each hit or fill through one access strobe. It supplies the way, and for a fill it also supplies the quantized cost of the miss that just completed. The block does not compare tags, store data or measure miss cost. A two-state machine tracks whether the set still has empty ways. In `ST_FILLING` the victim is the lowest-numbered invalid way. The transition to `ST_FULL` fires on the fill that makes the last invalid way valid. From then on the weighted score decides. Only reset returns the machine to `ST_FILLING`.

Top module: `cost_lru_victim`

## Requirements
- R1: After reset every way is invalid, way i holds stack position i, every cost is 0, and `victim_way` is 0.
- R2: While any way is invalid, `victim_way` is the lowest-numbered invalid way, whatever the recency, cost or weight.
- R3: The score of a way is its stack position plus `cost_weight` times its cost, computed exactly with no wrap. The largest score, 15 + 7 × 7 = 64, must lose to any smaller score.
- R4: With all ways valid, `victim_way` is a way whose score is the smallest in the set.
- R5: When two ways share the smallest score, the one with the lower stack position is chosen. Any tie that remains goes to the lower way index.
- R6: With `cost_weight` equal to 0 and all ways valid, `victim_way` is the way at stack position 0.
- R7: On an access (`acc_en` high, hit or fill), the way `acc_way` moves to position 15. Each way above its old position drops by one, and ways below it keep their positions. Accessing the way already at position 15 changes nothing.
- R8: A fill (`acc_fill` high with `acc_en`) marks `acc_way` valid and stores `fill_cost` as its cost. A hit (`acc_fill` low) leaves every cost unchanged.
- R9: `victim_way` reflects the state written at the clock edge that accepted an access, within the same cycle. It follows a change of `cost_weight` with no clock edge in between.
- R10: The machine moves from `ST_FILLING` to `ST_FULL` on the fill that makes the last invalid way valid. From then on the victim follows the score rather than the lowest index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_en | input | 1 | Access strobe, one per hit or fill |
| acc_fill | input | 1 | With `acc_en`: 1 marks a fill, 0 a hit |
| acc_way | input | 4 | Way being accessed |
| fill_cost | input | 3 | Quantized miss cost stored on a fill |
| cost_weight | input | 3 | Significance weight applied to cost |
| victim_way | output | 4 | Way proposed for eviction |

## Verification
All set state is written on the rising edge that samples `acc_en`. The victim is combinational from that state and from `cost_weight`. A hit or fill driven before edge k therefore shows its effect on `victim_way` in the half cycle after edge k. The bench drives every stimulus on a falling edge and reads the result on the following falling edge, one register stage later. Weight-only changes are read one time unit after they are driven, with no clock edge in between, which confirms there is no hidden register on that path.

// File: rtl/cost_lru_pkg.sv
package cost_lru_pkg;

    // Set occupancy: empty ways remain, or every way holds a line.
    typedef enum logic [0:0] {
        ST_FILLING = 1'b0,
        ST_FULL    = 1'b1
    } fill_state_e;

endpackage

// File: rtl/cost_lru_stack.sv
module cost_lru_stack #(
    parameter  int unsigned WAYS   = 16,
    parameter  int unsigned COST_W = 3,
    localparam int unsigned REC_W  = $clog2(WAYS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           acc_en,
    input  logic                           acc_fill,
    input  logic [REC_W-1:0]               acc_way,
    input  logic [COST_W-1:0]              fill_cost,
    output logic [WAYS-1:0][REC_W-1:0]     rec_o,
    output logic [WAYS-1:0][COST_W-1:0]    cost_o,
    output logic [WAYS-1:0]                valid_o
);

    localparam logic [REC_W-1:0] MRU_POS = REC_W'(WAYS - 1);

    logic [WAYS-1:0][REC_W-1:0]  rec_q;
    logic [WAYS-1:0][COST_W-1:0] cost_q;
    logic [WAYS-1:0]             valid_q;
    logic [REC_W-1:0]            old_pos;

    assign old_pos = rec_q[acc_way];

    // Recency stack: accessed way to the top, ways above it slide down.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WAYS; i++) begin
                rec_q[i] <= REC_W'(i);
            end
        end else if (acc_en) begin
            for (int i = 0; i < WAYS; i++) begin
                if (acc_way == REC_W'(i)) begin
                    rec_q[i] <= MRU_POS;
                end else if (rec_q[i] > old_pos) begin
                    rec_q[i] <= rec_q[i] - 1'b1;
                end
            end
        end
    end

    // Line occupancy and stored cost change only on a fill.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            cost_q  <= '0;
        end else if (acc_en && acc_fill) begin
            valid_q[acc_way] <= 1'b1;
            cost_q[acc_way]  <= fill_cost;
        end
    end

    assign rec_o   = rec_q;
    assign cost_o  = cost_q;
    assign valid_o = valid_q;

    logic [WAYS-1:0] pos_seen;
    always_comb begin
        pos_seen = '0;
        for (int i = 0; i < WAYS; i++) begin
            pos_seen[rec_q[i]] = 1'b1;
        end
    end

    AST_MRU_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |=> rec_q[$past(acc_way)] == MRU_POS); // R7

    AST_STACK_IS_PERMUTATION: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(pos_seen) == WAYS); // R7

    AST_FILL_STORES_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_fill) |=> (cost_q[$past(acc_way)] == $past(fill_cost)) && valid_q[$past(acc_way)]); // R8

    AST_HIT_KEEPS_COST: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_fill) |=> $stable(cost_q)); // R8

endmodule

// File: rtl/cost_lru_score.sv
module cost_lru_score #(
    parameter  int unsigned WAYS     = 16,
    parameter  int unsigned COST_W   = 3,
    parameter  int unsigned WEIGHT_W = 3,
    localparam int unsigned REC_W    = $clog2(WAYS),
    localparam int unsigned SCORE_W  = REC_W + COST_W + WEIGHT_W
) (
    input  logic [WAYS-1:0][REC_W-1:0]    rec_i,
    input  logic [WAYS-1:0][COST_W-1:0]   cost_i,
    input  logic [WEIGHT_W-1:0]           weight_i,
    output logic [WAYS-1:0][SCORE_W-1:0]  score_o
);

    // One exact adder-multiplier per way; width covers the full product.
    for (genvar g = 0; g < WAYS; g++) begin : g_way
        assign score_o[g] = SCORE_W'(rec_i[g]) + (SCORE_W'(cost_i[g]) * SCORE_W'(weight_i));
    end

endmodule

// File: rtl/cost_lru_argmin.sv
module cost_lru_argmin #(
    parameter  int unsigned WAYS    = 16,
    parameter  int unsigned SCORE_W = 10,
    localparam int unsigned REC_W   = $clog2(WAYS),
    localparam int unsigned KEY_W   = SCORE_W + REC_W
) (
    input  logic [WAYS-1:0][SCORE_W-1:0] score_i,
    input  logic [WAYS-1:0][REC_W-1:0]   rec_i,
    output logic [REC_W-1:0]             best_o
);

    logic [KEY_W-1:0] best_key;
    logic [KEY_W-1:0] cand_key;

    // Key orders by score, then by stack position; scanning upward with a
    // strict compare leaves any remaining tie on the lower index.
    always_comb begin
        best_key = {score_i[0], rec_i[0]};
        best_o   = '0;
        cand_key = '0;
        for (int i = 1; i < WAYS; i++) begin
            cand_key = {score_i[i], rec_i[i]};
            if (cand_key < best_key) begin
                best_key = cand_key;
                best_o   = REC_W'(i);
            end
        end
    end

endmodule

// File: rtl/cost_lru_victim.sv
module cost_lru_victim
    import cost_lru_pkg::*;
#(
    parameter  int unsigned WAYS     = 16,
    parameter  int unsigned COST_W   = 3,
    parameter  int unsigned WEIGHT_W = 3,
    localparam int unsigned REC_W    = $clog2(WAYS),
    localparam int unsigned SCORE_W  = REC_W + COST_W + WEIGHT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_en,
    input  logic                acc_fill,
    input  logic [REC_W-1:0]    acc_way,
    input  logic [COST_W-1:0]   fill_cost,
    input  logic [WEIGHT_W-1:0] cost_weight,
    output logic [REC_W-1:0]    victim_way
);

    logic [WAYS-1:0][REC_W-1:0]   rec;
    logic [WAYS-1:0][COST_W-1:0]  cost;
    logic [WAYS-1:0]              valid;
    logic [WAYS-1:0][SCORE_W-1:0] score;
    logic [REC_W-1:0]             best_way;
    logic [REC_W-1:0]             first_invalid;
    logic                         last_fill;
    fill_state_e                  state_q, state_d;

    cost_lru_stack #(.WAYS(WAYS), .COST_W(COST_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_en    (acc_en),
        .acc_fill  (acc_fill),
        .acc_way   (acc_way),
        .fill_cost (fill_cost),
        .rec_o     (rec),
        .cost_o    (cost),
        .valid_o   (valid)
    );

    cost_lru_score #(.WAYS(WAYS), .COST_W(COST_W), .WEIGHT_W(WEIGHT_W)) u_score (
        .rec_i    (rec),
        .cost_i   (cost),
        .weight_i (cost_weight),
        .score_o  (score)
    );

    cost_lru_argmin #(.WAYS(WAYS), .SCORE_W(SCORE_W)) u_argmin (
        .score_i (score),
        .rec_i   (rec),
        .best_o  (best_way)
    );

    // Lowest-numbered empty way.
    always_comb begin
        first_invalid = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                first_invalid = REC_W'(i);
            end
        end
    end

    assign last_fill = acc_en && acc_fill && (&(valid | (WAYS'(1) << acc_way)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILLING;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILLING: if (last_fill) state_d = ST_FULL;
            ST_FULL:    state_d = ST_FULL;
            default:    state_d = ST_FILLING;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_FILLING: victim_way = first_invalid;
            ST_FULL:    victim_way = best_way;
            default:    victim_way = '0;
        endcase
    end

    AST_FULL_MEANS_ALL_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) |-> (&valid)); // R10

    AST_FILLING_PICKS_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FILLING) |-> !valid[victim_way]); // R2

    AST_ZERO_WEIGHT_IS_LRU: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && cost_weight == '0) |-> (rec[victim_way] == '0)); // R6

    for (genvar j = 0; j < WAYS; j++) begin : g_chk
        AST_VICTIM_MINIMAL: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_FULL) |-> (score[victim_way] <= score[j])); // R4

        AST_TIE_TO_OLDER: assert property (@(posedge clk) disable iff (!rst_n)
            (state_q == ST_FULL && score[victim_way] == score[j]) |-> (rec[victim_way] <= rec[j])); // R5
    end

endmodule

// File: tb/cost_lru_victim_test.sv
module cost_lru_victim_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_en = 1'b0;
    logic       acc_fill = 1'b0;
    logic [3:0] acc_way = '0;
    logic [2:0] fill_cost = '0;
    logic [2:0] cost_weight = '0;
    logic [3:0] victim_way;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cost_lru_victim uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_en      (acc_en),
        .acc_fill    (acc_fill),
        .acc_way     (acc_way),
        .fill_cost   (fill_cost),
        .cost_weight (cost_weight),
        .victim_way  (victim_way)
    );

    // op: 0 none, 1 hit, 2 fill
    typedef struct packed {
        logic [1:0] op;
        logic [3:0] way;
        logic [2:0] cost;
        logic [2:0] wt;
        logic [3:0] exp_v;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 25;
    // Start state: full set, way i at position i, costs w0=7 w1=1 w3=1 w15=7.
    localparam vec_t VECS [NV] = '{
        {2'd0, 4'd0,  3'd0, 3'd0, 4'd0,  4'd6},
        {2'd0, 4'd0,  3'd0, 3'd1, 4'd1,  4'd5},
        {2'd0, 4'd0,  3'd0, 3'd2, 4'd2,  4'd4},
        {2'd0, 4'd0,  3'd0, 3'd7, 4'd2,  4'd3},
        {2'd1, 4'd0,  3'd0, 3'd0, 4'd1,  4'd7},
        {2'd1, 4'd1,  3'd0, 3'd0, 4'd2,  4'd7},
        {2'd1, 4'd5,  3'd0, 3'd0, 4'd2,  4'd7},
        {2'd1, 4'd2,  3'd0, 3'd0, 4'd3,  4'd7},
        {2'd2, 4'd3,  3'd5, 3'd0, 4'd4,  4'd8},
        {2'd2, 4'd4,  3'd6, 3'd0, 4'd6,  4'd8},
        {2'd0, 4'd0,  3'd0, 3'd7, 4'd6,  4'd4},
        {2'd2, 4'd6,  3'd2, 3'd0, 4'd7,  4'd8},
        {2'd1, 4'd6,  3'd0, 3'd0, 4'd7,  4'd7},
        {2'd2, 4'd7,  3'd7, 3'd0, 4'd8,  4'd7},
        {2'd1, 4'd8,  3'd0, 3'd0, 4'd9,  4'd7},
        {2'd1, 4'd9,  3'd0, 3'd0, 4'd10, 4'd7},
        {2'd1, 4'd10, 3'd0, 3'd0, 4'd11, 4'd7},
        {2'd1, 4'd11, 3'd0, 3'd0, 4'd12, 4'd7},
        {2'd1, 4'd12, 3'd0, 3'd0, 4'd13, 4'd7},
        {2'd1, 4'd13, 3'd0, 3'd0, 4'd14, 4'd7},
        {2'd1, 4'd14, 3'd0, 3'd0, 4'd15, 4'd7},
        {2'd1, 4'd15, 3'd0, 3'd0, 4'd0,  4'd7},
        {2'd1, 4'd0,  3'd0, 3'd0, 4'd1,  4'd7},
        {2'd0, 4'd0,  3'd0, 3'd2, 4'd5,  4'd8},
        {2'd0, 4'd0,  3'd0, 3'd1, 4'd1,  4'd5}
    };

    function automatic string tag(input logic [3:0] code);
        case (code)
            4'd1:    return "R1";
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            4'd9:    return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [2:0] fill_cost_of(input int k);
        case (k)
            0, 15:   return 3'd7;
            1, 3:    return 3'd1;
            default: return 3'd0;
        endcase
    endfunction

    task automatic check(input logic [3:0] got, input logic [3:0] exp_v, input string req);
        checks++;
        if (got !== exp_v) begin
            fails++;
            $display("FAIL %s: victim_way=%0d expected %0d", req, got, exp_v);
        end
    endtask

    // Drive on a falling edge, let one rising edge take it, read on the next falling edge.
    task automatic step(input logic [1:0] op, input logic [3:0] way,
                        input logic [2:0] cst, input logic [2:0] wt);
        @(negedge clk);
        acc_en      = (op != 2'd0);
        acc_fill    = (op == 2'd2);
        acc_way     = way;
        fill_cost   = cst;
        cost_weight = wt;
        @(negedge clk);
        acc_en   = 1'b0;
        acc_fill = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(victim_way, 4'd0, "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check(victim_way, 4'd0, "R1");

        // In-order fills: the next empty way is offered until the set is full.
        for (int k = 0; k < 16; k++) begin
            step(2'd2, 4'(k), fill_cost_of(k), 3'd0);
            if (k < 15) check(victim_way, 4'(k + 1), "R2");
            else        check(victim_way, 4'd0, "R10");
        end

        for (int v = 0; v < NV; v++) begin
            step(VECS[v].op, VECS[v].way, VECS[v].cost, VECS[v].wt);
            check(victim_way, VECS[v].exp_v, tag(VECS[v].req));
        end

        // R9: weight alone steers the victim with no clock edge between.
        @(negedge clk);
        cost_weight = 3'd2;
        #1 check(victim_way, 4'd5, "R9");
        cost_weight = 3'd0;
        #1 check(victim_way, 4'd1, "R9");

        // R1: reset in the middle of operation empties the set.
        do_reset();
        check(victim_way, 4'd0, "R1");
        cost_weight = 3'd7;
        #1 check(victim_way, 4'd0, "R1");

        // R2: fills out of index order.
        step(2'd2, 4'd3, 3'd0, 3'd7);
        check(victim_way, 4'd0, "R2");
        step(2'd2, 4'd0, 3'd0, 3'd7);
        check(victim_way, 4'd1, "R2");
        step(2'd2, 4'd1, 3'd0, 3'd0);
        check(victim_way, 4'd2, "R2");
        step(2'd2, 4'd2, 3'd0, 3'd0);
        check(victim_way, 4'd4, "R2");
        for (int k = 4; k < 16; k++) begin
            step(2'd2, 4'(k), 3'd0, 3'd0);
            if (k < 15) check(victim_way, 4'(k + 1), "R2");
        end
        // R10: once full, way 3 is the least recent, not the lowest index.
        check(victim_way, 4'd3, "R10");
        step(2'd1, 4'd3, 3'd0, 3'd0);
        check(victim_way, 4'd0, "R10");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule